// File: doc/BRIEF.md
# Two-Phase Configuration Port Slave

This block is the receiving end of a narrow byte-wide configuration port that a controller drives slowly from software-timed register writes. A transaction has two phases on one strobe. While the address-enable pin is high, a falling edge of the port strobe loads the byte on the data-in pin as the current register code. With address-enable low, the next rising edge of the strobe stores the data-in byte into the register that code selects. Between transactions the strobe rests high.

The slave holds a clock-lane control byte, one high-speed receive control byte per data lane and a settle-time control byte. All of them drive outputs toward the receiver. The data-out pin always shows the register chosen by the current code. Every port pin comes from another clock domain, so each passes through two flops into the system clock domain, and strobe edges are found there. The port has no stream traffic, so no valid/ready handshake applies and all pins are plain levels. The strobe must stay at each level for at least three system clock cycles, and data-in and address-enable must settle at least three cycles before the strobe edge that uses them.

Top module: `tp_cfg_slave`

## Requirements
- R1: After rst_n is released, every control output and tp_dout_o read zero, and the current code is 0x00.
- R2: A falling strobe edge with tp_aen_i high makes tp_din_i the current code. From then on, tp_dout_o shows the register for that code.
- R3: A rising strobe edge with tp_aen_i low writes tp_din_i into the register selected by the current code.
- R4: Code 0x44 selects data lane 0, 0x54 lane 1, 0x84 lane 2 and 0x94 lane 3. Lane n drives lane_ctl_o[8n+7:8n].
- R5: Code 0x34 selects clk_lane_ctl_o and code 0x75 selects settle_ctl_o.
- R6: Code 0x00 is the normal-operation code. A data write while it is selected changes no control output.
- R7: A write to any other code changes no control output, and tp_dout_o reads 0x00 while such a code is selected.
- R8: While tp_clr_i is held high, all control registers and the current code are cleared.
- R9: A rising edge with tp_aen_i high writes nothing. A falling edge with tp_aen_i low leaves the current code unchanged.
- R10: Changes on tp_din_i and tp_aen_i while the strobe stays high change neither the code nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tp_clk_i | input | 1 | Port strobe, idles high |
| tp_aen_i | input | 1 | Address-enable: high marks the code phase |
| tp_din_i | input | DW | Code or data byte |
| tp_clr_i | input | 1 | Clear of all configuration state, active high |
| tp_dout_o | output | DW | Register selected by the current code |
| clk_lane_ctl_o | output | DW | Clock-lane control register |
| lane_ctl_o | output | LANES*DW | Data-lane receive control registers, lane 0 in the low byte |
| settle_ctl_o | output | DW | Settle-time control register |

## Verification
Directed transactions write and read back every implemented code, one at a time, so that a decode slip shows up as a wrong output byte. Writes to code 0x00 and to an unused code show whether a write can reach a register it should not. Strobe edges taken with the wrong address-enable level, and changes on the data-in pin while the strobe is high, separate correct edge qualification from level-sensitive capture. A long run of random strobe half-cycles with random enable levels and random bytes, mixed with clear pulses, is compared against a reference model in the bench. This run finds ordering errors between the code phase and the data phase that the directed cases do not reach.

// File: rtl/tp_cfg_pkg.sv
package tp_cfg_pkg;
  localparam int unsigned MAX_LANES = 4;
  localparam logic [7:0] CODE_NORMAL  = 8'h00;
  localparam logic [7:0] CODE_CLKLANE = 8'h34;
  localparam logic [7:0] CODE_SETTLE  = 8'h75;

  // data-lane register codes; the gaps between them are not regular
  function automatic logic [7:0] lane_code(int unsigned idx);
    case (idx)
      0:       lane_code = 8'h44;
      1:       lane_code = 8'h54;
      2:       lane_code = 8'h84;
      3:       lane_code = 8'h94;
      default: lane_code = 8'h44;
    endcase
  endfunction

  function automatic logic code_known(logic [7:0] c, int unsigned lanes);
    logic hit;
    hit = (c == CODE_CLKLANE) || (c == CODE_SETTLE);
    for (int unsigned i = 0; i < MAX_LANES; i++)
      if (i < lanes && c == lane_code(i)) hit = 1'b1;
    code_known = hit;
  endfunction
endpackage

// File: rtl/tp_sync.sv
module tp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/tp_phase.sv
module tp_phase #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_s,
  input  logic          aen_s,
  input  logic          clr_s,
  input  logic [DW-1:0] din_s,
  output logic          cap_evt,
  output logic          wr_evt,
  output logic [DW-1:0] code_q
);
  logic strobe_d;
  logic fall, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b1;
    else        strobe_d <= strobe_s;
  end

  assign fall    = strobe_d & ~strobe_s;
  assign rise    = ~strobe_d & strobe_s;
  assign cap_evt = fall & aen_s & ~clr_s;
  assign wr_evt  = rise & ~aen_s & ~clr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (clr_s)   code_q <= '0;
    else if (cap_evt) code_q <= din_s;
  end
endmodule

// File: rtl/tp_regfile.sv
module tp_regfile
  import tp_cfg_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_s,
  input  logic                wr_evt,
  input  logic [DW-1:0]       code,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       clk_lane_q,
  output logic [DW-1:0]       settle_q,
  output logic [LANES*DW-1:0] lane_vec,
  output logic [DW-1:0]       rdata
);
  logic hit_clk, hit_settle;
  logic [LANES-1:0] hit_lane;

  assign hit_clk    = (code == DW'(CODE_CLKLANE));
  assign hit_settle = (code == DW'(CODE_SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  clk_lane_q <= '0;
    else if (clr_s)              clk_lane_q <= '0;
    else if (wr_evt && hit_clk)  clk_lane_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    settle_q <= '0;
    else if (clr_s)                settle_q <= '0;
    else if (wr_evt && hit_settle) settle_q <= wdata;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DW-1:0] lane_q;
    assign hit_lane[i] = (code == DW'(lane_code(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    lane_q <= '0;
      else if (clr_s)                lane_q <= '0;
      else if (wr_evt && hit_lane[i]) lane_q <= wdata;
    end
    assign lane_vec[i*DW +: DW] = lane_q;
  end

  always_comb begin
    rdata = '0;
    if (hit_clk)    rdata = clk_lane_q;
    if (hit_settle) rdata = settle_q;
    for (int i = 0; i < LANES; i++)
      if (hit_lane[i]) rdata = lane_vec[i*DW +: DW];
  end
endmodule

// File: rtl/tp_cfg_slave.sv
module tp_cfg_slave
  import tp_cfg_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tp_clk_i,
  input  logic                tp_aen_i,
  input  logic [DW-1:0]       tp_din_i,
  input  logic                tp_clr_i,
  output logic [DW-1:0]       tp_dout_o,
  output logic [DW-1:0]       clk_lane_ctl_o,
  output logic [LANES*DW-1:0] lane_ctl_o,
  output logic [DW-1:0]       settle_ctl_o
);
  localparam int unsigned SW = DW + 3;
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << DW; // strobe idles high

  logic [SW-1:0] raw_bus, sync_bus;
  logic          strobe_s, aen_s, clr_s;
  logic [DW-1:0] din_s;
  logic          cap_evt, wr_evt;
  logic [DW-1:0] code_q;

  assign raw_bus = {tp_clr_i, tp_aen_i, tp_clk_i, tp_din_i};

  tp_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign din_s    = sync_bus[DW-1:0];
  assign strobe_s = sync_bus[DW];
  assign aen_s    = sync_bus[DW+1];
  assign clr_s    = sync_bus[DW+2];

  tp_phase #(.DW(DW)) u_phase (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .aen_s(aen_s),
    .clr_s(clr_s), .din_s(din_s), .cap_evt(cap_evt), .wr_evt(wr_evt),
    .code_q(code_q)
  );

  tp_regfile #(.DW(DW), .LANES(LANES)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .wr_evt(wr_evt),
    .code(code_q), .wdata(din_s), .clk_lane_q(clk_lane_ctl_o),
    .settle_q(settle_ctl_o), .lane_vec(lane_ctl_o), .rdata(tp_dout_o)
  );
endmodule

// File: rtl/tp_cfg_chk.sv
module tp_cfg_chk
  import tp_cfg_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tp_clr_i,
  input logic                cap_evt,
  input logic                wr_evt,
  input logic                clr_s,
  input logic [DW-1:0]       code_q,
  input logic [DW-1:0]       tp_dout_o,
  input logic [DW-1:0]       clk_lane_ctl_o,
  input logic [LANES*DW-1:0] lane_ctl_o,
  input logic [DW-1:0]       settle_ctl_o
);
  logic [1:0] clr_run;
  logic [LANES*DW+2*DW-1:0] cfg_all;

  assign cfg_all = {clk_lane_ctl_o, lane_ctl_o, settle_ctl_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clr_run <= '0;
    else if (!tp_clr_i) clr_run <= '0;
    else if (clr_run != 2'd3) clr_run <= clr_run + 2'd1;
  end

  // R8
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_run == 2'd3) |-> (cfg_all == '0 && tp_dout_o == '0));

  // R3
  cfg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_all) |-> $past(wr_evt || clr_s));

  // R2
  code_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(cap_evt || clr_s));

  // R6
  normal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_evt && code_q == '0) |-> $stable(cfg_all));

  // R7
  unknown_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_known(8'(code_q), LANES) |-> (tp_dout_o == '0));
endmodule

bind tp_cfg_slave tp_cfg_chk #(.DW(DW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tp_clr_i(tp_clr_i), .cap_evt(cap_evt),
  .wr_evt(wr_evt), .clr_s(clr_s), .code_q(code_q), .tp_dout_o(tp_dout_o),
  .clk_lane_ctl_o(clk_lane_ctl_o), .lane_ctl_o(lane_ctl_o),
  .settle_ctl_o(settle_ctl_o)
);

// File: tb/tb_tp_cfg_slave.sv
module tb_tp_cfg_slave;
  localparam int DW = 8;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tp_clk = 1'b1, tp_aen = 1'b0, tp_clr = 1'b0;
  logic [DW-1:0] tp_din = '0;
  logic [DW-1:0] tp_dout, clk_lane, settle;
  logic [LANES*DW-1:0] lanes;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_code, m_clk, m_settle;
  logic [7:0] m_lane [LANES];

  always #4 clk = ~clk;

  tp_cfg_slave #(.DW(DW), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .tp_clk_i(tp_clk), .tp_aen_i(tp_aen),
    .tp_din_i(tp_din), .tp_clr_i(tp_clr), .tp_dout_o(tp_dout),
    .clk_lane_ctl_o(clk_lane), .lane_ctl_o(lanes), .settle_ctl_o(settle)
  );

  function automatic int lane_idx(logic [7:0] c);
    case (c)
      8'h44: return 0;
      8'h54: return 1;
      8'h84: return 2;
      8'h94: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] c);
    if (c == 8'h34) return m_clk;
    if (c == 8'h75) return m_settle;
    if (lane_idx(c) >= 0) return m_lane[lane_idx(c)];
    return 8'h00;
  endfunction

  function automatic void m_write(logic [7:0] d);
    if (m_code == 8'h34) m_clk = d;
    else if (m_code == 8'h75) m_settle = d;
    else if (lane_idx(m_code) >= 0) m_lane[lane_idx(m_code)] = d;
  endfunction

  function automatic void m_clear();
    m_code = '0; m_clk = '0; m_settle = '0;
    for (int i = 0; i < LANES; i++) m_lane[i] = '0;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp(req, "dout", tp_dout, exp_read(m_code));
    cmp(req, "clk_lane", clk_lane, m_clk);
    cmp(req, "settle", settle, m_settle);
    for (int i = 0; i < LANES; i++)
      cmp(req, $sformatf("lane%0d", i), lanes[i*8 +: 8], m_lane[i]);
  endtask

  task automatic strobe_fall(logic en, logic [7:0] d);
    tp_aen = en; tp_din = d; wait_cyc(4);
    tp_clk = 1'b0; wait_cyc(5);
    if (en) m_code = d;
  endtask

  task automatic strobe_rise(logic en, logic [7:0] d);
    tp_aen = en; tp_din = d; wait_cyc(4);
    tp_clk = 1'b1; wait_cyc(5);
    if (!en) m_write(d);
  endtask

  task automatic xfer(logic [7:0] c, logic [7:0] d);
    strobe_fall(1'b1, c);
    strobe_rise(1'b0, d);
  endtask

  task automatic clear_pulse();
    tp_clr = 1'b1; wait_cyc(5);
    m_clear();
    check_all("R8");
    tp_clr = 1'b0; wait_cyc(4);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_clear();
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check_all("R1");

    // R4 R5: each implemented code written and read back
    xfer(8'h44, 8'hA1); check_all("R4");
    xfer(8'h54, 8'hB2); check_all("R4");
    xfer(8'h84, 8'hC3); check_all("R4");
    xfer(8'h94, 8'hD4); check_all("R4");
    xfer(8'h34, 8'h5E); check_all("R5");
    xfer(8'h75, 8'h04); check_all("R5");
    // R2: reselect a lane and read it on dout
    strobe_fall(1'b1, 8'h54); check_all("R2");
    strobe_rise(1'b1, 8'h77); check_all("R9");
    // R3: data phase to the held code
    strobe_fall(1'b0, 8'h99); check_all("R9");
    strobe_rise(1'b0, 8'h3C); check_all("R3");
    // R6: normal-operation code
    xfer(8'h00, 8'hFF); check_all("R6");
    // R7: unused code
    xfer(8'h55, 8'hEE); check_all("R7");
    cmp("R7", "dout_unused", tp_dout, 8'h00);
    // R10: data and enable wiggle with strobe high
    strobe_fall(1'b1, 8'h34);
    strobe_rise(1'b1, 8'h34);
    for (int k = 0; k < 6; k++) begin
      tp_aen = k[0]; tp_din = 8'(k * 37); wait_cyc(3);
    end
    check_all("R10");
    clear_pulse();
    xfer(8'h94, 8'h11); check_all("R3");

    // random strobe half-cycles against the model
    for (int it = 0; it < 400; it++) begin
      logic [7:0] pick;
      case ($urandom % 8)
        0: pick = 8'h44;
        1: pick = 8'h54;
        2: pick = 8'h84;
        3: pick = 8'h94;
        4: pick = 8'h34;
        5: pick = 8'h75;
        6: pick = 8'h00;
        default: pick = 8'($urandom);
      endcase
      if ($urandom % 40 == 0) clear_pulse();
      strobe_fall(($urandom % 4) != 0, pick);
      strobe_rise(($urandom % 4) == 0, 8'($urandom));
      check_all("R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule